// File: doc/BRIEF.md
# Tree and Butterfly Route Unit

This block decides the next hop for a packet at one switch of either a k-ary tree or a 2-ary butterfly network. A request carries the source node address, the destination node address, the level (or stage) of the switch making the decision, and a mode bit. The route is derived arithmetically. The unit takes the bitwise exclusive-or of the two addresses and locates its highest nonzero radix digit with a leading-digit detector. No routing table is used.

In tree mode the highest differing digit sets the turn level, which is the level of the lowest common ancestor. Below that level the packet climbs. At or above it the packet descends, and the destination digit belonging to the current level selects the child port. In butterfly mode the exclusive-or bit for the stage selects either the straight edge or the cross edge. Only one path exists between any pair of nodes, so the choice is fully deterministic. Requests use a valid/ready handshake. The answer is registered and stays held until the consumer takes it.

Top module: `route_unit`

Addresses are `DIGITS` digits of `DIGIT_W` bits each (defaults 4 and 1, giving 16 nodes in a binary tree). Digit 0 is the least significant. Levels are numbered from 0, which is the source node. Switch level j is the ancestor whose subtree holds radix^j nodes.

## Requirements
- R1: In tree mode, `rspTurn` equals one plus the index of the most significant nonzero digit of src XOR dst, and it is 0 when the addresses are equal. In butterfly mode, `rspTurn` is 0.
- R2: In tree mode with src different from dst, a level below the turn level gives `rspDir` UP (code 1).
- R3: In tree mode with src different from dst, a level at or above the turn level gives `rspDir` DOWN (code 2), with `rspPort` equal to destination digit (level-1). For every direction other than DOWN, `rspPort` is 0.
- R4: In tree mode with src equal to dst, the result is LOCAL (code 0) at every level.
- R5: In butterfly mode, the stage given in `reqLevel` yields STRAIGHT (code 3) when bit `reqLevel` of src and dst agree, and CROSS (code 4) when they differ. Equal addresses give STRAIGHT at every stage.
- R6: Out-of-range levels clamp. In tree mode a level above `DIGITS` behaves as level `DIGITS`. In butterfly mode a stage at or above the address width uses the top address bit.
- R7: After reset `rspValid` is low. A request accepted on a clock edge (`reqValid` and `reqReady` high) produces `rspValid` high, with its result, from that edge onward. `reqReady` is high whenever `rspValid` is low.
- R8: While `rspValid` is high and `rspReady` is low, the response fields and `rspValid` hold steady and `reqReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can take a request |
| reqSrc | input | DIGITS*DIGIT_W | Source node address |
| reqDst | input | DIGITS*DIGIT_W | Destination node address |
| reqLevel | input | clog2(DIGITS*DIGIT_W+1) | Tree level or butterfly stage |
| reqMode | input | 1 | 0 selects tree, 1 selects butterfly |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| rspDir | output | 3 | 0 local, 1 up, 2 down, 3 straight, 4 cross |
| rspPort | output | DIGIT_W | Child port on a downward hop |
| rspTurn | output | clog2(DIGITS*DIGIT_W+1) | Tree turn level |

## Verification
The assertions check the handshake on every cycle. A response follows each acceptance, a stalled response stays frozen, and ready is offered whenever the output is empty. They also check two cross-field rules: a non-downward hop carries port 0, and a local result carries turn 0. Whether each up, down, straight or cross choice is correct can only be shown by the bench scenarios. The bench sweeps every source and destination pair at every level in both modes, including levels beyond range. It compares each result with a model that walks the tree by shifting addresses, while random back-pressure is applied.

// File: rtl/route_pkg.sv
package route_pkg;

  typedef enum logic [2:0] {
    DIR_LOCAL    = 3'd0,
    DIR_UP       = 3'd1,
    DIR_DOWN     = 3'd2,
    DIR_STRAIGHT = 3'd3,
    DIR_CROSS    = 3'd4
  } route_dir_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } route_strb_t;

endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        rspValid,
  output route_strb_t strb
);

  logic validQ;

  assign reqReady  = !validQ || rspReady;
  assign strb.load = reqValid && reqReady;
  assign rspValid  = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strb.load) begin
      validQ <= 1'b1;
    end else if (rspReady) begin
      validQ <= 1'b0;
    end
  end

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_ready_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> reqReady);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |-> !reqReady);

endmodule

// File: rtl/route_datapath.sv
module route_datapath
  import route_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int DIGIT_W = 1,
  localparam int ADDR_W = DIGITS * DIGIT_W,
  localparam int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  route_strb_t       strb,
  input  logic [ADDR_W-1:0] reqSrc,
  input  logic [ADDR_W-1:0] reqDst,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic              reqMode,
  output route_dir_t        rspDir,
  output logic [DIGIT_W-1:0] rspPort,
  output logic [LVL_W-1:0]  rspTurn
);

  logic [ADDR_W-1:0] relAddr;
  logic [DIGITS-1:0] digitHit;
  logic [LVL_W-1:0]  turnLvl;
  int                lvlInt;
  int                treeLvl;
  int                bflyStage;
  logic              crossBit;
  logic [DIGIT_W-1:0] downPort;
  route_dir_t        nextDir;
  logic [DIGIT_W-1:0] nextPort;
  logic [LVL_W-1:0]  nextTurn;

  assign relAddr = reqSrc ^ reqDst;

  // one nonzero flag per radix digit
  for (genvar d = 0; d < DIGITS; d++) begin : gDigit
    assign digitHit[d] = |relAddr[d*DIGIT_W +: DIGIT_W];
  end

  // leading-digit detector: highest flagged digit wins
  always_comb begin
    turnLvl = '0;
    for (int d = 0; d < DIGITS; d++) begin
      if (digitHit[d]) turnLvl = LVL_W'(d + 1);
    end
  end

  always_comb begin
    lvlInt    = int'(reqLevel);
    treeLvl   = (lvlInt > DIGITS) ? DIGITS : lvlInt;
    bflyStage = (lvlInt >= ADDR_W) ? (ADDR_W - 1) : lvlInt;
  end

  // destination digit for the current descent level
  always_comb begin
    downPort = '0;
    for (int d = 0; d < DIGITS; d++) begin
      if (d == treeLvl - 1) downPort = reqDst[d*DIGIT_W +: DIGIT_W];
    end
  end

  always_comb begin
    crossBit = 1'b0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (b == bflyStage) crossBit = relAddr[b];
    end
  end

  always_comb begin
    nextDir  = DIR_LOCAL;
    nextPort = '0;
    nextTurn = '0;
    if (reqMode) begin
      nextDir = crossBit ? DIR_CROSS : DIR_STRAIGHT;
    end else begin
      nextTurn = turnLvl;
      if (turnLvl == '0) begin
        nextDir = DIR_LOCAL;
      end else if (treeLvl < int'(turnLvl)) begin
        nextDir = DIR_UP;
      end else begin
        nextDir  = DIR_DOWN;
        nextPort = downPort;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDir  <= DIR_LOCAL;
      rspPort <= '0;
      rspTurn <= '0;
    end else if (strb.load) begin
      rspDir  <= nextDir;
      rspPort <= nextPort;
      rspTurn <= nextTurn;
    end
  end

  assert_port_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspDir != DIR_DOWN) |-> (rspPort == '0));

  assert_local_turn_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspDir == DIR_LOCAL) |-> (rspTurn == '0));

endmodule

// File: rtl/route_unit.sv
module route_unit
  import route_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int DIGIT_W = 1,
  localparam int ADDR_W = DIGITS * DIGIT_W,
  localparam int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqSrc,
  input  logic [ADDR_W-1:0]  reqDst,
  input  logic [LVL_W-1:0]   reqLevel,
  input  logic               reqMode,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [2:0]         rspDir,
  output logic [DIGIT_W-1:0] rspPort,
  output logic [LVL_W-1:0]   rspTurn
);

  route_strb_t strb;
  route_dir_t  dirQ;

  route_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strb     (strb)
  );

  route_datapath #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqSrc   (reqSrc),
    .reqDst   (reqDst),
    .reqLevel (reqLevel),
    .reqMode  (reqMode),
    .rspDir   (dirQ),
    .rspPort  (rspPort),
    .rspTurn  (rspTurn)
  );

  assign rspDir = dirQ;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=>
      (rspValid && $stable(rspDir) && $stable(rspPort) && $stable(rspTurn)));

endmodule

// File: tb/tb_route_unit.sv
module tb_route_unit;

  localparam int DIGITS  = 4;
  localparam int DIGIT_W = 1;
  localparam int ADDR_W  = DIGITS * DIGIT_W;
  localparam int LVL_W   = $clog2(ADDR_W + 1);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [ADDR_W-1:0]  reqSrc = '0;
  logic [ADDR_W-1:0]  reqDst = '0;
  logic [LVL_W-1:0]   reqLevel = '0;
  logic               reqMode = 1'b0;
  logic               rspValid;
  logic               rspReady = 1'b1;
  logic [2:0]         rspDir;
  logic [DIGIT_W-1:0] rspPort;
  logic [LVL_W-1:0]   rspTurn;

  int checks = 0;
  int failures = 0;
  bit stallMode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]         dir;
    logic [DIGIT_W-1:0] port;
    logic [LVL_W-1:0]   turn;
    string              tag;
  } exp_t;

  exp_t scoreQ[$];

  always #10 clk = ~clk;

  route_unit #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSrc(reqSrc), .reqDst(reqDst), .reqLevel(reqLevel), .reqMode(reqMode),
    .rspValid(rspValid), .rspReady(rspReady), .rspDir(rspDir),
    .rspPort(rspPort), .rspTurn(rspTurn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: climb by shifting until the two subtrees coincide
  function automatic exp_t model(input int src, input int dst, input int lvl, input bit mode);
    exp_t e;
    int t = 0;
    int l;
    e.dir = 3'd0; e.port = '0; e.turn = '0;
    if (mode) begin
      int s = (lvl >= ADDR_W) ? ADDR_W - 1 : lvl;
      e.dir = (((src >> s) & 1) != ((dst >> s) & 1)) ? 3'd4 : 3'd3;
      e.tag = (lvl >= ADDR_W) ? "R6" : "R5";
      return e;
    end
    if (src != dst) begin
      for (int j = 1; j <= DIGITS; j++) begin
        if (t == 0 && (src >> (DIGIT_W * j)) == (dst >> (DIGIT_W * j))) t = j;
      end
    end
    e.turn = LVL_W'(t);
    l = (lvl > DIGITS) ? DIGITS : lvl;
    if (t == 0) begin
      e.dir = 3'd0; e.tag = "R4";
    end else if (l < t) begin
      e.dir = 3'd1; e.tag = "R2";
    end else begin
      e.dir = 3'd2; e.tag = "R3";
      e.port = DIGIT_W'((dst >> (DIGIT_W * (l - 1))) & ((1 << DIGIT_W) - 1));
    end
    if (lvl > DIGITS) e.tag = "R6";
    return e;
  endfunction

  task automatic send(input int src, input int dst, input int lvl, input bit mode);
    @(negedge clk); #1;
    reqValid = 1'b1;
    reqSrc   = ADDR_W'(src);
    reqDst   = ADDR_W'(dst);
    reqLevel = LVL_W'(lvl);
    reqMode  = mode;
    #7;
    while (!reqReady) begin
      @(negedge clk); #8;
    end
    scoreQ.push_back(model(src, dst, lvl, mode));
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // consumer back-pressure
  initial begin
    forever begin
      @(negedge clk); #1;
      rspReady = stallMode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor samples 2 ns before each rising edge
  initial begin
    bit prevStall = 1'b0;
    logic [2:0] hDir;
    logic [DIGIT_W-1:0] hPort;
    logic [LVL_W-1:0] hTurn;
    exp_t e;
    forever begin
      @(negedge clk); #8;
      if (rstN) begin
        if (prevStall) begin
          check(rspValid && rspDir == hDir && rspPort == hPort && rspTurn == hTurn,
                "R8 hold", int'(rspDir), int'(hDir));
        end
        if (rspValid && !rspReady) begin
          check(!reqReady, "R8 ready low", int'(reqReady), 0);
          prevStall = 1'b1; hDir = rspDir; hPort = rspPort; hTurn = rspTurn;
        end else begin
          prevStall = 1'b0;
        end
        if (rspValid && rspReady) begin
          if (scoreQ.size() == 0) begin
            check(1'b0, "R7 unexpected response", 1, 0);
          end else begin
            e = scoreQ.pop_front();
            check(rspDir == e.dir, {e.tag, " dir"}, int'(rspDir), int'(e.dir));
            check(rspPort == e.port, {e.tag, " port R3"}, int'(rspPort), int'(e.port));
            check(rspTurn == e.turn, {e.tag, " turn R1"}, int'(rspTurn), int'(e.turn));
          end
        end
        if (!rspValid) check(reqReady, "R7 ready when empty", int'(reqReady), 1);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!rspValid, "R7 reset valid", int'(rspValid), 0);
    check(reqReady, "R7 reset ready", int'(reqReady), 1);
    rstN = 1'b1;

    // single request: response valid the cycle after acceptance
    @(negedge clk); #1;
    reqValid = 1'b1; reqSrc = 4'd3; reqDst = 4'd12; reqLevel = 3'd0; reqMode = 1'b0;
    scoreQ.push_back(model(3, 12, 0, 1'b0));
    @(posedge clk); #1;
    reqValid = 1'b0;
    check(rspValid, "R7 valid after accept", int'(rspValid), 1);
    check(rspDir == 3'd1, "R2 first hop up", int'(rspDir), 1);

    // exhaustive sweep without stalls
    for (int m = 0; m < 2; m++)
      for (int lv = 0; lv < (1 << LVL_W); lv++)
        for (int s = 0; s < (1 << ADDR_W); s++)
          for (int d = 0; d < (1 << ADDR_W); d++)
            send(s, d, lv, m[0]);

    // repeat a slice with random consumer stalls
    stallMode = 1'b1;
    for (int lv = 0; lv < (1 << LVL_W); lv++)
      for (int s = 0; s < (1 << ADDR_W); s += 3)
        for (int d = 0; d < (1 << ADDR_W); d += 2) begin
          send(s, d, lv, 1'b0);
          send(d, s, lv, 1'b1);
        end
    stallMode = 1'b0;

    repeat (10) @(posedge clk);
    check(scoreQ.size() == 0, "R7 all responses delivered", scoreQ.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7 watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule